// File: doc/BRIEF.md
# Ultra DMA Burst Pin-Role Controller

This device-side block decides when an Ultra DMA data burst is under way and gives the shared host and device control pins their burst meanings for that time. It raises the device DMA request when Ultra DMA transfers are enabled and a read or write DMA command is pending. When the host answers with its active-low acknowledge, the block enters a read or a write burst. When the host withdraws the acknowledge, the block drops back to the ordinary pin meanings.

In a read burst the shared host pin is the host's active-low ready signal, and the device pin is the device strobe. Each change of the strobe level, rising or falling, hands the host one 16-bit word, which the block takes from a local word source. In a write burst the shared host pin is the host strobe, and the device pin is the device's active-low ready signal. Every host strobe edge, in either direction, captures one word from the data bus and gives a one-cycle valid pulse. The host pins are asynchronous, so they pass through a synchronizer, and the data bus is delayed by the same number of stages so that each word lines up with its strobe edge. A host STOP lets the word in flight complete, withdraws the request, and holds until the acknowledge is released.

Top module: `udma_burst_ctl`

## Requirements
- R1: The DMA request goes high only while Ultra DMA is enabled and a read or write command is pending. A burst starts only after the request is up and the synchronized acknowledge is low. With Ultra DMA disabled, a low acknowledge leaves the bus undriven and the device pin high.
- R2: When the host drives the acknowledge high, any burst or termination state returns to idle. After that the bus is undriven (bus_oe = 0) and the device pin is high.
- R3: In a read burst the bus is driven, the device strobe starts high, and each change of its level presents the next word from the source. Words come out in the order the source gave them, one pop for each strobe change.
- R4: In a read burst, a high host pin (host not ready) stops the device strobe from toggling. The burst stays in place with the request high, and toggling resumes when the pin goes low.
- R5: In a write burst the device pin is low (device ready). Each rising or falling edge of the host pin captures one bus word into wr_word and pulses wr_valid for one cycle.
- R6: STOP completes the word in flight, drops the DMA request, and leaves the strobe still. After a write burst the device pin goes high (not ready). The block waits for the acknowledge to rise before it returns to idle.
- R7: Host pin edges outside a write burst produce no wr_valid pulse. This covers idle, waiting for the acknowledge, and termination.
- R8: After reset the request is low, the bus is undriven, the device pin is high, and wr_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| udma_en | input | 1 | An Ultra DMA transfer mode is selected |
| cmd_rd | input | 1 | A read DMA command needing data is pending |
| cmd_wr | input | 1 | A write DMA command needing data is pending |
| dmack_n | input | 1 | Host DMA acknowledge, active low, asynchronous |
| stop_req | input | 1 | Host STOP request, asynchronous |
| host_pin | input | 1 | Shared host pin: ready (active low) in a read burst, strobe in a write burst |
| bus_in | input | 16 | Data bus as seen by the device |
| rd_avail | input | 1 | The read source holds a word |
| rd_data | input | 16 | Word offered by the read source |
| rd_pop | output | 1 | Word taken from the read source this cycle |
| dmarq | output | 1 | Device DMA request |
| dev_pin | output | 1 | Shared device pin: strobe in a read burst, ready (active low) in a write burst, high otherwise |
| bus_out | output | 16 | Word driven onto the data bus |
| bus_oe | output | 1 | Data bus drive enable |
| wr_valid | output | 1 | One-cycle pulse when a host word has been captured |
| wr_word | output | 16 | Last captured host word |

## Verification
Write bursts send all-zero, all-one and alternating-bit words, so a word captured on the wrong strobe edge or with misaligned bits shows up as a mismatch. Strobe edges in both directions are used, which separates correct dual-edge capture from single-edge capture. Read bursts start with the host not ready, then pause partway, which separates a strobe that waits for the ready signal from one that runs free. A STOP in the middle of a read checks that the number of strobe changes equals the number of words popped. Host pin toggles while idle, while waiting for the acknowledge and during termination must produce no captures, which separates gated capture from capture that is always on.

// File: rtl/udma_pkg.sv
// Package: shared state and direction encodings for the Ultra DMA burst controller.
package udma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_ACK  = 3'd1,
        ST_RD_BURST  = 3'd2,
        ST_WR_BURST  = 3'd3,
        ST_TERMINATE = 3'd4
    } burst_state_e;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } burst_dir_e;
endpackage

// File: rtl/udma_sync.sv
// Multi-stage synchronizer for asynchronous host inputs.
// Assumes each bit is treated on its own; buses must be qualified by a
// separately synchronized strobe delayed by the same number of stages.
module udma_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            // Later stages let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/udma_edge_det.sv
// Level-change detector: compares a synchronized level with its delayed copy.
// Assumes the input is already in the clk domain.
module udma_edge_det #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic edge_o
);
    logic lvl_d;

    // Hold the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= RST_VAL;
        else        lvl_d <= lvl;
    end

    assign edge_o = lvl ^ lvl_d;
endmodule

// File: rtl/udma_burst_fsm.sv
// Burst state machine: request, acknowledge, read/write burst, termination.
// Assumes cmd_rd/cmd_wr/udma_en are synchronous; dmack_n_s and stop_s are
// already synchronized. A read command wins if both are pending.
module udma_burst_fsm
    import udma_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         udma_en,
    input  logic         cmd_rd,
    input  logic         cmd_wr,
    input  logic         dmack_n_s,
    input  logic         stop_s,
    input  logic         rd_busy,
    output burst_state_e state,
    output burst_dir_e   dir,
    output logic         dmarq,
    output logic         rd_go,
    output logic         rd_active,
    output logic         wr_en
);
    burst_state_e state_q, state_d;
    burst_dir_e   dir_q;
    logic         want;

    assign want = udma_en && (cmd_rd || cmd_wr);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:      if (want) state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (!want)          state_d = ST_IDLE;
                else if (!dmack_n_s) state_d = cmd_rd ? ST_RD_BURST : ST_WR_BURST;
            end
            ST_RD_BURST: begin
                if (dmack_n_s)              state_d = ST_IDLE;
                else if (stop_s && !rd_busy) state_d = ST_TERMINATE;
            end
            ST_WR_BURST: begin
                if (dmack_n_s)   state_d = ST_IDLE;
                else if (stop_s) state_d = ST_TERMINATE;
            end
            ST_TERMINATE: if (dmack_n_s) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the burst direction when the host acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= DIR_WRITE;
        else if (state_q == ST_WAIT_ACK && state_d != ST_WAIT_ACK && state_d != ST_IDLE)
            dir_q <= cmd_rd ? DIR_READ : DIR_WRITE;
    end

    assign state     = state_q;
    assign dir       = dir_q;
    assign dmarq     = (state_q == ST_WAIT_ACK) || (state_q == ST_RD_BURST) ||
                       (state_q == ST_WR_BURST);
    assign rd_go     = (state_q == ST_RD_BURST) && !stop_s;
    assign rd_active = (state_q == ST_RD_BURST) ||
                       (state_q == ST_TERMINATE && dir_q == DIR_READ);
    assign wr_en     = (state_q == ST_WR_BURST);

    // R1: a burst is never entered straight from idle.
    assert_ack_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !(state_q inside {ST_RD_BURST, ST_WR_BURST}));

    // R2: a high acknowledge in any burst state ends it.
    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q inside {ST_RD_BURST, ST_WR_BURST, ST_TERMINATE}) && dmack_n_s)
        |=> (state_q == ST_IDLE));

    // R6: termination waits for the acknowledge to rise.
    assert_term_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TERMINATE && !dmack_n_s) |=> (state_q == ST_TERMINATE));
endmodule

// File: rtl/udma_rd_path.sv
// Read data path: loads a word, then toggles the device strobe one cycle later.
// Assumes hrdy_n_s is the synchronized host-ready (active low).
module udma_rd_path #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_active,
    input  logic              rd_go,
    input  logic              hrdy_n_s,
    input  logic              rd_avail,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_pop,
    output logic              dstrobe,
    output logic [DATA_W-1:0] data_out,
    output logic              busy
);
    logic              phase_q;
    logic              dstrobe_q;
    logic [DATA_W-1:0] data_q;
    logic              load;

    assign load = rd_go && !hrdy_n_s && rd_avail && !phase_q;

    // Two-phase sequencing: set up data, then strobe it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= 1'b0;
            dstrobe_q <= 1'b1;
            data_q    <= '0;
        end else if (!rd_active) begin
            phase_q   <= 1'b0;
            dstrobe_q <= 1'b1;
        end else if (phase_q) begin
            dstrobe_q <= ~dstrobe_q;
            phase_q   <= 1'b0;
        end else if (load) begin
            data_q  <= rd_data;
            phase_q <= 1'b1;
        end
    end

    assign rd_pop   = load;
    assign dstrobe  = dstrobe_q;
    assign data_out = data_q;
    assign busy     = phase_q;

    // R3: data is stable across every strobe change.
    assert_data_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && $past(rd_active) && !$stable(dstrobe_q)) |-> $stable(data_q));

    // R4: no strobe change without a word loaded under host-ready.
    assert_pause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && $past(rd_active) && $past(hrdy_n_s) && !$past(phase_q))
        |-> $stable(dstrobe_q));
endmodule

// File: rtl/udma_wr_path.sv
// Write capture path: one word per host strobe edge while the burst allows it.
// Assumes data_s is delayed to align with the detected strobe edge.
module udma_wr_path #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              strobe_edge,
    input  logic [DATA_W-1:0] data_s,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_word
);
    logic              valid_q;
    logic [DATA_W-1:0] word_q;

    // Capture the aligned word on either strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            valid_q <= wr_en && strobe_edge;
            if (wr_en && strobe_edge) word_q <= data_s;
        end
    end

    assign wr_valid = valid_q;
    assign wr_word  = word_q;

    // R7: captures happen only out of a write burst cycle.
    assert_capture_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(wr_en));
endmodule

// File: rtl/udma_burst_ctl.sv
// Top: Ultra DMA burst pin-role controller (device side).
// Synchronizes host pins, runs the burst FSM and maps the shared pins
// to their read or write burst roles. Assumes bus_in is stable from before
// a host strobe edge until SYNC_STAGES+2 clocks after it.
module udma_burst_ctl
    import udma_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              udma_en,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic              dmack_n,
    input  logic              stop_req,
    input  logic              host_pin,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              rd_avail,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_pop,
    output logic              dmarq,
    output logic              dev_pin,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_word
);
    localparam int CTRL_W = 3;

    logic [CTRL_W-1:0] ctrl_s;
    logic              hpin_s, dmack_n_s, stop_s;
    logic [DATA_W-1:0] data_s;
    logic              hpin_edge;
    burst_state_e      state;
    burst_dir_e        dir;
    logic              rd_go, rd_active, wr_en, rd_busy, dstrobe;

    udma_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_ctrl_sync (
        .clk(clk), .rst_n(rst_n), .d({host_pin, dmack_n, stop_req}), .q(ctrl_s));
    assign {hpin_s, dmack_n_s, stop_s} = ctrl_s;

    udma_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_in), .q(data_s));

    udma_edge_det #(.RST_VAL(1'b1)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(hpin_s), .edge_o(hpin_edge));

    udma_burst_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .udma_en(udma_en), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .dmack_n_s(dmack_n_s), .stop_s(stop_s), .rd_busy(rd_busy),
        .state(state), .dir(dir), .dmarq(dmarq), .rd_go(rd_go),
        .rd_active(rd_active), .wr_en(wr_en));

    udma_rd_path #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_active(rd_active), .rd_go(rd_go),
        .hrdy_n_s(hpin_s), .rd_avail(rd_avail), .rd_data(rd_data), .rd_pop(rd_pop),
        .dstrobe(dstrobe), .data_out(bus_out), .busy(rd_busy));

    udma_wr_path #(.DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .strobe_edge(hpin_edge),
        .data_s(data_s), .wr_valid(wr_valid), .wr_word(wr_word));

    // Device pin role follows the burst state and direction.
    always_comb begin
        case (state)
            ST_RD_BURST:  dev_pin = dstrobe;
            ST_WR_BURST:  dev_pin = 1'b0;
            ST_TERMINATE: dev_pin = (dir == DIR_READ) ? dstrobe : 1'b1;
            default:      dev_pin = 1'b1;
        endcase
    end

    assign bus_oe = rd_active;

    // R6: once STOP has been seen the request stays down until idle.
    assert_stop_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TERMINATE) |-> !dmarq);

    // R5: the device never drives the bus while the host is writing.
    assert_no_drive_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !bus_oe);
endmodule

// File: tb/udma_burst_ctl_tb_top.sv
module udma_burst_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic udma_en = 0, cmd_rd = 0, cmd_wr = 0, dmack_n = 1, stop_req = 0, host_pin = 1;
    logic [DW-1:0] bus_in = '0;
    logic rd_avail, rd_pop, dmarq, dev_pin, bus_oe, wr_valid;
    logic [DW-1:0] rd_data, bus_out, wr_word;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [DW-1:0] src_mem [0:31];
    int src_len = 0, src_idx = 0;
    logic [DW-1:0] exp_q [$];
    bit mode_read = 0;
    int toggles = 0, wr_seen = 0;
    logic prev_pin = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    udma_burst_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .udma_en(udma_en), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .dmack_n(dmack_n), .stop_req(stop_req), .host_pin(host_pin), .bus_in(bus_in),
        .rd_avail(rd_avail), .rd_data(rd_data), .rd_pop(rd_pop), .dmarq(dmarq),
        .dev_pin(dev_pin), .bus_out(bus_out), .bus_oe(bus_oe), .wr_valid(wr_valid),
        .wr_word(wr_word));

    // Read word source model.
    assign rd_avail = (src_idx < src_len);
    assign rd_data  = src_mem[src_idx[4:0]];
    always @(posedge clk) if (rd_pop) src_idx <= src_idx + 1;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Scoreboard monitor: pops expected words as the design produces them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                wr_seen++;
                if (exp_q.size() == 0) check(0, "R7 unexpected capture", wr_word, '0);
                else begin
                    logic [DW-1:0] w;
                    w = exp_q.pop_front();
                    check(wr_word == w, "R5 write word", wr_word, w);
                end
            end
            if (mode_read && bus_oe && dev_pin != prev_pin) begin
                toggles++;
                if (exp_q.size() == 0) check(0, "R3 extra strobe", bus_out, '0);
                else begin
                    logic [DW-1:0] w;
                    w = exp_q.pop_front();
                    check(bus_out == w, "R3 read word", bus_out, w);
                end
            end
        end
        prev_pin = dev_pin;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_read(input logic [DW-1:0] w);
        src_mem[src_len[4:0]] = w;
        src_len++;
        exp_q.push_back(w);
    endtask

    task automatic send_word(input logic [DW-1:0] w);
        @(negedge clk);
        bus_in = w;
        exp_q.push_back(w);
        cyc(2);
        host_pin = ~host_pin;
        cyc(5);
    endtask

    task automatic wait_drain(input string req);
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, req, 16'(exp_q.size()), '0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int t0, idx0;
        cyc(3);
        // R8: reset state
        check(dmarq == 0, "R8 dmarq", 16'(dmarq), 0);
        check(bus_oe == 0, "R8 bus_oe", 16'(bus_oe), 0);
        check(dev_pin == 1, "R8 dev_pin", 16'(dev_pin), 1);
        check(wr_valid == 0, "R8 wr_valid", 16'(wr_valid), 0);
        @(negedge clk); rst_n = 1;

        // R1: no request and no burst without the mode enabled
        cmd_rd = 1; dmack_n = 0; cyc(6);
        check(dmarq == 0, "R1 dmarq without mode", 16'(dmarq), 0);
        check(bus_oe == 0, "R1 no burst without mode", 16'(bus_oe), 0);
        check(dev_pin == 1, "R1 dev_pin without mode", 16'(dev_pin), 1);
        cmd_rd = 0; dmack_n = 1; cyc(4);

        // R7: host pin edges while idle and while waiting are ignored
        t0 = wr_seen;
        host_pin = 0; cyc(5); host_pin = 1; cyc(5);
        udma_en = 1; cmd_wr = 1; cyc(3);
        check(dmarq == 1, "R1 dmarq with mode and command", 16'(dmarq), 1);
        host_pin = 0; cyc(5); host_pin = 1; cyc(5);
        check(wr_seen == t0, "R7 idle/wait edges ignored", 16'(wr_seen), 16'(t0));
        cmd_wr = 0; cyc(4);

        // Read burst, starting with host not ready (R3, R4)
        mode_read = 1; host_pin = 1;
        for (int i = 0; i < 6; i++) push_read(16'h1100 + 16'(i * 16'h0101));
        cmd_rd = 1; cyc(3);
        check(bus_oe == 0, "R1 no drive before acknowledge", 16'(bus_oe), 0);
        dmack_n = 0; cyc(8);
        check(bus_oe == 1, "R3 bus driven in read", 16'(bus_oe), 1);
        check(toggles == 0, "R4 no strobe while not ready", 16'(toggles), 0);
        check(dmarq == 1, "R4 burst held while not ready", 16'(dmarq), 1);
        host_pin = 0;
        for (int i = 0; i < 300 && toggles < 3; i++) @(negedge clk);
        host_pin = 1; cyc(8);
        t0 = toggles; cyc(10);
        check(toggles == t0, "R4 strobe paused", 16'(toggles), 16'(t0));
        check(dmarq == 1, "R4 request held in pause", 16'(dmarq), 1);
        host_pin = 0;
        wait_drain("R3 all read words strobed");
        check(toggles == 6, "R3 strobe count", 16'(toggles), 6);
        check(src_idx == 6, "R3 pops", 16'(src_idx), 6);
        stop_req = 1; cyc(6);
        check(dmarq == 0, "R6 dmarq after stop (read)", 16'(dmarq), 0);
        cmd_rd = 0; dmack_n = 1; stop_req = 0; cyc(6);
        check(bus_oe == 0, "R2 bus released", 16'(bus_oe), 0);
        check(dev_pin == 1, "R2 dev_pin idle", 16'(dev_pin), 1);

        // Read burst stopped mid-stream (R6)
        idx0 = src_idx; toggles = 0;
        for (int i = 0; i < 10; i++) push_read(16'hC000 ^ 16'(i * 16'h0F0F));
        cmd_rd = 1; cyc(3); dmack_n = 0; cyc(7);
        stop_req = 1; cyc(12);
        check(toggles == src_idx - idx0, "R6 in-flight word completed",
              16'(toggles), 16'(src_idx - idx0));
        check(toggles < 10, "R6 stop halted strobe", 16'(toggles), 16'(10));
        check(dmarq == 0, "R6 dmarq low", 16'(dmarq), 0);
        t0 = toggles; cyc(6);
        check(toggles == t0, "R6 strobe still", 16'(toggles), 16'(t0));
        exp_q.delete(); src_len = src_idx;
        cmd_rd = 0; cyc(2); dmack_n = 1; stop_req = 0; cyc(6);
        check(bus_oe == 0, "R2 bus released after stop", 16'(bus_oe), 0);
        mode_read = 0;

        // Write burst (R5)
        t0 = wr_seen;
        cmd_wr = 1; cyc(3); dmack_n = 0; cyc(6);
        check(dev_pin == 0, "R5 device ready", 16'(dev_pin), 0);
        check(bus_oe == 0, "R5 bus not driven", 16'(bus_oe), 0);
        send_word(16'h0000); send_word(16'hFFFF); send_word(16'hA5A5);
        send_word(16'h5A5A); send_word(16'h8001); send_word(16'h1234);
        wait_drain("R5 all write words captured");
        check(wr_seen - t0 == 6, "R5 one capture per edge", 16'(wr_seen - t0), 6);
        stop_req = 1; cyc(6);
        check(dmarq == 0, "R6 dmarq after stop (write)", 16'(dmarq), 0);
        check(dev_pin == 1, "R6 device not ready", 16'(dev_pin), 1);
        t0 = wr_seen;
        host_pin = ~host_pin; cyc(6);
        check(wr_seen == t0, "R7 edge in termination ignored", 16'(wr_seen), 16'(t0));
        cmd_wr = 0; dmack_n = 1; stop_req = 0; cyc(6);
        check(dev_pin == 1, "R2 dev_pin after write", 16'(dev_pin), 1);
        host_pin = ~host_pin; cyc(6);
        check(wr_seen == t0, "R7 edge after burst ignored", 16'(wr_seen), 16'(t0));

        report();
    end
endmodule